// File: doc/BRIEF.md
# Quad Output Flash Read Controller

This block is the host side of a serial NOR flash read that returns data on four lines. A one-cycle start request that is accepted pulls chip select low. The controller then shifts out an 8-bit read command and a 24-bit or 32-bit address on IO0 alone. It runs eight further clocks with every IO line released. From then on it collects four data bits per serial clock until the requested number of bytes has arrived. Each assembled byte leaves on a plain valid/data stream, and a done pulse marks the last one.

The serial clock comes from the system clock through a half-period divider (`DIV_HALF` system cycles per level) and idles low, which suits SPI mode 0. Host output bits change on the falling serial edge. Returned data is sampled on the rising edge. A read that asks for zero bytes, or that arrives while the quad-enable input is low, is refused with an error pulse and the bus is not touched. After each transfer chip select stays high for a guaranteed deselect time before the next request can be taken.

Top module: `qflash_rd`

## Requirements
- R1: After reset `csN` is 1, `sclk` is 0, `ioOe` is 0, and `busy`, `rdValid`, `done` and `refused` are 0.
- R2: The first 8 rising `sclk` edges of a transfer carry the command byte 0x6B on `ioOut[0]`, most significant bit first, with `ioOe[0]` set. `sclk` is 0 whenever `csN` is 1.
- R3: The next rising edges carry the address MSB first on `ioOut[0]`. When `addr4B`=1 this is 32 bits (`addr[31:0]`). When `addr4B`=0 it is 24 bits (`addr[23:0]`).
- R4: Exactly 8 dummy clocks follow the address. `ioOe` is 0000 from the first dummy clock until chip select rises. The total number of rising edges is 8 + address bits + 8 + 2 × `byteCount`.
- R5: Each byte is built from two nibbles sampled on `ioIn[3:0]` (IO3 is bit 3). The first nibble is bits 7..4 and the second is bits 3..0. Successive bytes come from successive flash addresses.
- R6: `rdValid` is a one-cycle pulse per byte, and exactly `byteCount` pulses occur per transfer.
- R7: `done` pulses in the same cycle as the `rdValid` of the final byte, and at no other time.
- R8: `busy` and a low `csN` begin in the cycle after an accepted start and last until chip select rises. Rising `sclk` edges are `2*DIV_HALF` system cycles apart.
- R9: A start with `quadEn`=0 or `byteCount`=0 gives a one-cycle `refused` pulse in the next cycle. In that case `csN` stays high and `busy` stays low.
- R10: A start seen while `busy` is high, or during deselect, is ignored. With start held high, `csN` stays high for exactly `DESEL_CYC`+1 system cycles between two transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a read |
| addr | input | 32 | Flash start address |
| addr4B | input | 1 | 1 selects a 32-bit address, 0 a 24-bit address |
| byteCount | input | CNT_W | Number of bytes to read |
| quadEn | input | 1 | Quad read permitted |
| sclk | output | 1 | Serial clock |
| csN | output | 1 | Chip select, active low |
| ioOut | output | 4 | Values driven onto IO3..IO0 |
| ioOe | output | 4 | Output enables for IO3..IO0 |
| ioIn | input | 4 | Values seen on IO3..IO0 |
| rdValid | output | 1 | Byte strobe |
| rdData | output | 8 | Assembled byte |
| done | output | 1 | Final byte of the transfer |
| busy | output | 1 | Transfer in progress |
| refused | output | 1 | Start rejected |

## Verification
The last byte's `rdValid` and `done` must fire together in one cycle. The bench catches this by flagging any `done` that has no strobe beside it, and by checking at each `done` that the byte tally equals the requested count. Two other requests can also collide with a transfer: a start during a transfer, and a start held high across the deselect window. The first is provoked with a different address mid-transfer and judged by an unchanged byte stream followed by a quiet bus. The second is judged by measuring the exact chip-select high time before the next transfer.

// File: rtl/qfr_pkg.sv
package qfr_pkg;
  localparam logic [7:0] READ_CMD = 8'h6B;

  typedef struct packed {
    logic load;   // latch command and address into the shifter
    logic shift;  // advance serial output by one bit
    logic capHi;  // capture upper nibble
    logic capLo;  // capture lower nibble and emit byte
    logic last;   // current byte is the final one
  } qfr_strobe_t;
endpackage

// File: rtl/qfr_ctrl.sv
module qfr_ctrl
  import qfr_pkg::*;
#(
  parameter int DIV_HALF  = 2,
  parameter int CNT_W     = 16,
  parameter int DESEL_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             addr4B,
  input  logic [CNT_W-1:0] byteCount,
  input  logic             quadEn,
  output logic             sclk,
  output logic             csN,
  output logic             oe0,
  output logic             busy,
  output logic             refused,
  output qfr_strobe_t      stb
);
  localparam int HW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int KW = CNT_W + 2;
  localparam int DW = (DESEL_CYC > 1) ? $clog2(DESEL_CYC) : 1;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_DESEL} state_t;

  state_t          state;
  logic [HW-1:0]   halfCnt;
  logic [KW-1:0]   clkIdx, lastIdx, dataIdx;
  logic [CNT_W-1:0] bytesLeft;
  logic            hiNext;
  logic [DW-1:0]   deselCnt;

  logic tick, accept, reqOk, rising, falling, inData;

  assign tick    = (halfCnt == HW'(DIV_HALF - 1));
  assign accept  = (state == S_IDLE) && start;
  assign reqOk   = quadEn && (byteCount != '0);
  assign rising  = (state == S_XFER) && tick && !sclk;
  assign falling = (state == S_XFER) && tick && sclk;
  assign inData  = (clkIdx >= dataIdx);
  assign busy    = (state == S_XFER);

  always_comb begin
    stb.load  = accept && reqOk;
    stb.shift = falling && (clkIdx != lastIdx);
    stb.capHi = rising && inData && hiNext;
    stb.capLo = rising && inData && !hiNext;
    stb.last  = (bytesLeft == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      halfCnt   <= '0;
      sclk      <= 1'b0;
      csN       <= 1'b1;
      oe0       <= 1'b0;
      refused   <= 1'b0;
      clkIdx    <= '0;
      lastIdx   <= '0;
      dataIdx   <= '0;
      bytesLeft <= '0;
      hiNext    <= 1'b1;
      deselCnt  <= '0;
    end else begin
      refused <= accept && !reqOk;
      case (state)
        S_IDLE: begin
          if (accept && reqOk) begin
            state     <= S_XFER;
            csN       <= 1'b0;
            oe0       <= 1'b1;
            sclk      <= 1'b0;
            halfCnt   <= '0;
            clkIdx    <= '0;
            dataIdx   <= KW'(addr4B ? 48 : 40);
            lastIdx   <= KW'(addr4B ? 48 : 40) + (KW'(byteCount) << 1) - KW'(1);
            bytesLeft <= byteCount;
            hiNext    <= 1'b1;
          end
        end
        S_XFER: begin
          halfCnt <= tick ? '0 : halfCnt + HW'(1);
          if (tick) begin
            if (!sclk) begin
              sclk <= 1'b1;
              if (stb.capLo) bytesLeft <= bytesLeft - CNT_W'(1);
              if (stb.capHi || stb.capLo) hiNext <= !hiNext;
            end else begin
              sclk <= 1'b0;
              if (clkIdx == lastIdx) begin
                csN      <= 1'b1;
                oe0      <= 1'b0;
                state    <= S_DESEL;
                deselCnt <= DW'(DESEL_CYC - 1);
              end else begin
                clkIdx <= clkIdx + KW'(1);
                if (clkIdx + KW'(1) == dataIdx - KW'(8)) oe0 <= 1'b0;
              end
            end
          end
        end
        default: begin
          if (deselCnt == '0) state <= S_IDLE;
          else deselCnt <= deselCnt - DW'(1);
        end
      endcase
    end
  end
endmodule

// File: rtl/qfr_dp.sv
module qfr_dp
  import qfr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] addr,
  input  logic        addr4B,
  input  logic [3:0]  ioIn,
  input  qfr_strobe_t stb,
  output logic        io0,
  output logic        rdValid,
  output logic [7:0]  rdData,
  output logic        done
);
  logic [39:0] shiftReg;
  logic [3:0]  hiNib;

  assign io0 = shiftReg[39];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      hiNib    <= '0;
      rdValid  <= 1'b0;
      rdData   <= '0;
      done     <= 1'b0;
    end else begin
      if (stb.load)
        shiftReg <= addr4B ? {READ_CMD, addr} : {READ_CMD, addr[23:0], 8'h00};
      else if (stb.shift)
        shiftReg <= {shiftReg[38:0], 1'b0};
      if (stb.capHi) hiNib <= ioIn;
      if (stb.capLo) rdData <= {hiNib, ioIn};
      rdValid <= stb.capLo;
      done    <= stb.capLo && stb.last;
    end
  end
endmodule

// File: rtl/qflash_rd.sv
module qflash_rd
  import qfr_pkg::*;
#(
  parameter int DIV_HALF  = 2,
  parameter int CNT_W     = 16,
  parameter int DESEL_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [31:0]      addr,
  input  logic             addr4B,
  input  logic [CNT_W-1:0] byteCount,
  input  logic             quadEn,
  output logic             sclk,
  output logic             csN,
  output logic [3:0]       ioOut,
  output logic [3:0]       ioOe,
  input  logic [3:0]       ioIn,
  output logic             rdValid,
  output logic [7:0]       rdData,
  output logic             done,
  output logic             busy,
  output logic             refused
);
  qfr_strobe_t stb;
  logic io0, oe0;

  qfr_ctrl #(.DIV_HALF(DIV_HALF), .CNT_W(CNT_W), .DESEL_CYC(DESEL_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .addr4B(addr4B),
    .byteCount(byteCount), .quadEn(quadEn), .sclk(sclk), .csN(csN),
    .oe0(oe0), .busy(busy), .refused(refused), .stb(stb)
  );

  qfr_dp u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .addr4B(addr4B), .ioIn(ioIn),
    .stb(stb), .io0(io0), .rdValid(rdValid), .rdData(rdData), .done(done)
  );

  assign ioOut = {3'b000, io0};
  assign ioOe  = {3'b000, oe0};
endmodule

// File: rtl/qflash_rd_chk.sv
module qflash_rd_chk (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       sclk,
  input logic       busy,
  input logic       rdValid,
  input logic       done,
  input logic       refused,
  input logic [3:0] ioOe
);
  assert_busy_cs_R8: assert property (@(posedge clk) disable iff (!rstN) busy |-> !csN);
  assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rstN) csN |-> !sclk);
  assert_data_undriven_R4: assert property (@(posedge clk) disable iff (!rstN) rdValid |-> (ioOe == 4'b0000));
  assert_done_last_R7: assert property (@(posedge clk) disable iff (!rstN) done |-> rdValid);
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rstN) rdValid |=> !rdValid);
  assert_refuse_quiet_R9: assert property (@(posedge clk) disable iff (!rstN) refused |-> (csN && !busy));
  assert_deselect_R10: assert property (@(posedge clk) disable iff (!rstN) $rose(csN) |=> csN);
endmodule

bind qflash_rd qflash_rd_chk u_chk (.*);

// File: tb/qflash_rd_bench.sv
module qflash_rd_bench;
  localparam int DH = 2;
  localparam int DES = 2;
  localparam int CW = 16;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, addr4B = 1'b0, quadEn = 1'b0;
  logic [31:0] addr = '0;
  logic [CW-1:0] byteCount = '0;
  logic sclk, csN, rdValid, done, busy, refused;
  logic [3:0] ioOut, ioOe, ioIn;
  logic [7:0] rdData;

  int compared = 0, mismatched = 0, cyc = 0;

  always #5 clk = ~clk;

  qflash_rd #(.DIV_HALF(DH), .CNT_W(CW), .DESEL_CYC(DES)) u_qflash_rd (
    .clk(clk), .rstN(rstN), .start(start), .addr(addr), .addr4B(addr4B),
    .byteCount(byteCount), .quadEn(quadEn), .sclk(sclk), .csN(csN),
    .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn), .rdValid(rdValid),
    .rdData(rdData), .done(done), .busy(busy), .refused(refused)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] memByte(input logic [31:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h5A;
  endfunction

  // flash-side model state
  logic cur4B = 1'b0;
  logic [31:0] curAddr = '0;
  int curCnt = 0;
  logic prevSclk = 1'b0, prevCs = 1'b1;
  int rises = 0, nib = 0, lastRise = 0;
  logic [7:0] opc;
  logic [31:0] adrSeen;
  bit oeBad = 0, perBad = 0;

  // stream scoreboard
  logic [7:0] expQ[$];
  int rcv = 0;
  bit doneSeen = 0;
  bit prevValid = 0;

  always @(negedge clk) begin
    int aBits;
    logic [31:0] ba;
    logic [7:0] b;
    cyc++;
    aBits = cur4B ? 32 : 24;
    if (!csN && prevCs) begin
      rises = 0; nib = 0; opc = '0; adrSeen = '0; oeBad = 0; perBad = 0;
      ioIn = 4'h0;
    end
    if (!csN && sclk && !prevSclk) begin
      rises++;
      if (rises > 1 && (cyc - lastRise) != 2 * DH) perBad = 1;
      lastRise = cyc;
      if (rises <= 8) begin
        if (ioOe[0] !== 1'b1) oeBad = 1;
        opc = {opc[6:0], ioOut[0]};
        if (rises == 8) chk(opc == 8'h6B, "R2 opcode", opc, 8'h6B);
      end else if (rises <= 8 + aBits) begin
        if (ioOe[0] !== 1'b1) oeBad = 1;
        adrSeen = {adrSeen[30:0], ioOut[0]};
        if (rises == 8 + aBits)
          chk(adrSeen == (cur4B ? curAddr : {8'h00, curAddr[23:0]}), "R3 address",
              adrSeen, cur4B ? curAddr : {8'h00, curAddr[23:0]});
      end else begin
        if (ioOe !== 4'b0000) oeBad = 1;
      end
    end
    if (!csN && !sclk && prevSclk && rises >= 16 + aBits) begin
      ba = curAddr + 32'(nib / 2);
      if (!cur4B) ba[31:24] = 8'h00;
      b = memByte(ba);
      ioIn = (nib % 2 == 0) ? b[7:4] : b[3:0];
      nib++;
    end
    if (csN && !prevCs) begin
      chk(rises == 16 + aBits + 2 * curCnt, "R4 clock total", rises, 16 + aBits + 2 * curCnt);
      chk(!oeBad, "R4 drive enables", oeBad, 0);
      chk(!perBad, "R8 sclk period", perBad, 0);
    end
    if (rdValid) begin
      if (expQ.size() == 0) chk(0, "R6 extra byte", rdData, 0);
      else begin
        b = expQ.pop_front();
        chk(rdData == b, "R5 byte", rdData, b);
      end
      rcv++;
      chk(!prevValid, "R6 single pulse", 1, 0);
    end
    if (done) begin
      chk(rdValid, "R7 done with last byte", rdValid, 1);
      chk(rcv == curCnt, "R7 byte tally", rcv, curCnt);
      rcv = 0;
      doneSeen = 1;
    end
    prevValid = rdValid;
    prevSclk = sclk;
    prevCs = csN;
  end

  task automatic pushExp(input logic [31:0] a, input bit a4, input int cnt);
    for (int i = 0; i < cnt; i++) begin
      logic [31:0] ba;
      ba = a + 32'(i);
      if (!a4) ba[31:24] = 8'h00;
      expQ.push_back(memByte(ba));
    end
  endtask

  task automatic waitCsHigh();
    int t = 0;
    while (!csN && t < 20000) begin @(negedge clk); t++; end
  endtask

  task automatic runRead(input logic [31:0] a, input bit a4, input int cnt, input bit poke);
    @(negedge clk);
    addr = a; addr4B = a4; byteCount = CW'(cnt); quadEn = 1'b1;
    cur4B = a4; curAddr = a; curCnt = cnt; doneSeen = 0;
    pushExp(a, a4, cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!csN && busy, "R8 busy and select on accept", {busy, csN}, 2'b10);
    if (poke) begin
      repeat (30) @(negedge clk);
      addr = ~a; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waitCsHigh();
    chk(!busy, "R8 busy drops with select", busy, 0);
    chk(doneSeen, "R7 done seen", doneSeen, 1);
    chk(expQ.size() == 0, "R6 byte count", expQ.size(), 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    while (cyc < 150000) @(negedge clk);
    chk(0, "watchdog", cyc, 150000);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int gap;
    bit quiet;
    ioIn = 4'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(csN && !sclk && ioOe == 4'b0 && !busy && !rdValid && !done && !refused,
        "R1 reset state", {csN, sclk, ioOe, busy, rdValid, done, refused}, 10'h200);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runRead(32'h0012_3456, 1'b0, 5, 1'b0);   // R3 24-bit
    runRead(32'hA1B2_C3D4, 1'b1, 3, 1'b0);   // R3 32-bit
    runRead(32'h00FF_FFFE, 1'b0, 4, 1'b0);   // R5 consecutive over boundary
    runRead(32'h0000_0010, 1'b1, 1, 1'b0);   // R7 single byte

    // R10 start during busy is ignored
    runRead(32'h0045_6789, 1'b0, 6, 1'b1);
    quiet = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!csN || busy) quiet = 0;
    end
    chk(quiet, "R10 mid-transfer start ignored", quiet, 1);

    // R9 refused: quad disabled
    @(negedge clk);
    addr = 32'h1; byteCount = CW'(4); quadEn = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(refused && csN && !busy, "R9 refused quad off", {refused, csN, busy}, 3'b110);
    quiet = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!csN || busy || refused) quiet = 0;
    end
    chk(quiet, "R9 bus quiet after refusal", quiet, 1);

    // R9 refused: zero count
    addr = 32'h2; byteCount = '0; quadEn = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(refused && csN && !busy, "R9 refused zero count", {refused, csN, busy}, 3'b110);
    repeat (3) @(negedge clk);

    // R10 deselect gap with start held high
    addr = 32'h0000_0200; addr4B = 1'b0; byteCount = CW'(2); quadEn = 1'b1;
    cur4B = 1'b0; curAddr = 32'h0000_0200; curCnt = 2;
    pushExp(32'h0000_0200, 1'b0, 2);
    pushExp(32'h0000_0200, 1'b0, 2);
    start = 1'b1;
    @(negedge clk);
    waitCsHigh();
    gap = 0;
    while (csN && gap < 100) begin @(negedge clk); gap++; end
    start = 1'b0;
    chk(gap == DES + 1, "R10 deselect gap", gap, DES + 1);
    waitCsHigh();
    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R6 both held transfers complete", expQ.size(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule